// File: doc/BRIEF.md
# DMA Channel Context Identifier Bank

This block keeps one 32-bit context identifier for every DMA channel. Software in a privileged mode reaches the identifiers through a coprocessor-style system register port. A channel-number value, held outside the block and supplied on `chan_sel`, picks which channel's identifier a given access touches. The upper 24 bits of each identifier carry a process number. The lower 8 bits carry the address-space tag that the translation logic uses, and the block exports that tag for every channel all the time.

Every access is checked against the caller's privilege level, its security world and a non-secure DMA enable input. Secure privileged code may always read and write. Non-secure privileged code may do so only while the enable is set. User-mode code is always refused. A refused access, or a granted write to a channel that is running or queued, leaves the stored identifier unchanged. A refused access also returns an undefined-instruction flag to the core, which then takes the trap. The same storage serves both security worlds; it is not banked.

Top module: `dma_ctxid_bank`

## Requirements
- R1: After a synchronous reset every channel's identifier is 0, `asid_out` is all zeros and `rsp_valid` is low.
- R2: The block responds only to a strobe whose address fields are opcode1 = 0, primary register 11, secondary register 15 and opcode2 = 0. Any other strobe gives no response (`rsp_valid` stays low) and changes no identifier.
- R3: A decoded access with `acc_priv` = 0 returns `rsp_undef` = 1 with `rsp_rdata` = 0 and leaves every identifier unchanged.
- R4: A decoded privileged access with `acc_secure` = 1 is granted (`rsp_undef` = 0). A read returns the stored identifier. A write stores `acc_wdata`.
- R5: A decoded privileged access with `acc_secure` = 0 is granted when `ns_dma_en` = 1. When `ns_dma_en` = 0 it returns `rsp_undef` = 1, `rsp_rdata` = 0, and does not write.
- R6: A granted write to channel c while `chan_busy[c]` = 1 leaves that identifier unchanged and raises no undefined flag.
- R7: An access touches only the channel whose index equals `chan_sel`. Other channels keep their values.
- R8: When `chan_sel` is at or above the channel count, a granted read returns 0 and a granted write changes nothing. Neither raises the undefined flag.
- R9: The response (`rsp_valid`, `rsp_undef`, `rsp_rdata`) appears in the cycle after the strobe edge. For a read, the data is the value held before that edge. For a write, `rsp_rdata` is 0.
- R10: `asid_out[8*c+7:8*c]` equals bits [7:0] of channel c's identifier, and it reflects a write from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | Opcode1 field of the access |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Opcode2 field of the access |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged mode |
| acc_secure | input | 1 | 1 = secure world |
| ns_dma_en | input | 1 | Allows non-secure privileged access when 1 |
| chan_sel | input | SEL_W | Current channel-number register value |
| chan_busy | input | NUM_CH | Per channel: running or queued |
| rsp_valid | output | 1 | Response present |
| rsp_undef | output | 1 | Access refused, undefined-instruction trap |
| rsp_rdata | output | 32 | Read data |
| asid_out | output | 8*NUM_CH | Address-space tag of every channel |

## Verification
The bench aims at the edges of the access matrix:
- **Non-secure enable.** It toggles `ns_dma_en` under non-secure privileged access. A design that ignored the enable would grant the access and corrupt the stored value, or would trap even though the enable is set.
- **Busy channel.** It writes to busy channels. A design that dropped the busy gate would change `asid_out` under a running transfer, and one that treated busy as a refusal would wrongly raise `rsp_undef`.
- **Out-of-range channel.** It drives channel numbers past the implemented range. An index that wrapped would alias channel 0.
- **Address decode.** It sends near-miss address fields. A loose decode would answer them.
- **Read timing.** It checks that read data is the value held before the same edge's update, which catches a response that is one cycle early or late.

// File: rtl/dma_ctxid_pkg.sv
package dma_ctxid_pkg;

    localparam int WORD_W = 32;
    localparam int ASID_W = 8;
    localparam int PROC_W = WORD_W - ASID_W;

    localparam logic [2:0] OP1_CODE = 3'd0;
    localparam logic [3:0] CRN_CODE = 4'd11;
    localparam logic [3:0] CRM_CODE = 4'd15;
    localparam logic [2:0] OP2_CODE = 3'd0;

    typedef struct packed {
        logic [PROC_W-1:0] proc_id;
        logic [ASID_W-1:0] asid;
    } ctx_word_t;

    typedef struct packed {
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_addr_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_GRANT = 2'd1,
        ACC_DENY  = 2'd2
    } acc_verdict_t;

    function automatic logic addr_hit(input sysreg_addr_t a);
        return (a.op1 == OP1_CODE) && (a.crn == CRN_CODE) &&
               (a.crm == CRM_CODE) && (a.op2 == OP2_CODE);
    endfunction

    function automatic acc_verdict_t judge(input logic hit, input logic priv,
                                           input logic secure, input logic ns_en);
        if (!hit)
            return ACC_NONE;
        else if (priv && (secure || ns_en))
            return ACC_GRANT;
        else
            return ACC_DENY;
    endfunction

endpackage

// File: rtl/dma_ctxid_gate.sv
module dma_ctxid_gate
    import dma_ctxid_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 4
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  sysreg_addr_t       addr,
    input  logic               priv,
    input  logic               secure,
    input  logic               ns_en,
    input  logic [SEL_W-1:0]   chan_sel,
    input  logic [NUM_CH-1:0]  chan_busy,
    output acc_verdict_t       verdict,
    output logic               sel_ok,
    output logic [NUM_CH-1:0]  wr_vec
);

    localparam logic [SEL_W:0] CH_LIMIT = (SEL_W + 1)'(NUM_CH);

    always_comb begin
        verdict = acc_valid ? judge(addr_hit(addr), priv, secure, ns_en) : ACC_NONE;
        sel_ok  = ({1'b0, chan_sel} < CH_LIMIT);
    end

    // One write enable per channel: the channel must be selected and idle.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_wen
        assign wr_vec[c] = (verdict == ACC_GRANT) && acc_write &&
                           (chan_sel == SEL_W'(c)) && !chan_busy[c];
    end

endmodule

// File: rtl/dma_ctxid_store.sv
module dma_ctxid_store
    import dma_ctxid_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH-1:0]         wr_vec,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [SEL_W-1:0]          rd_idx,
    input  logic                      rd_ok,
    output logic [WORD_W-1:0]         rd_word,
    output logic [NUM_CH*ASID_W-1:0]  asid_flat
);

    ctx_word_t entry [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                entry[c] <= '0;
            else if (wr_vec[c])
                entry[c] <= ctx_word_t'(wr_data);
        end
        assign asid_flat[c*ASID_W +: ASID_W] = entry[c].asid;
    end

    always_comb begin
        rd_word = '0;
        if (rd_ok) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (rd_idx == SEL_W'(c))
                    rd_word = entry[c];
            end
        end
    end

    // R7: the gate must never enable more than one channel at a time
    always_comb begin
        if (!rst) begin
            p_one_target_r7: assert ($onehot0(wr_vec))
                else $error("more than one channel write-enabled");
        end
    end

endmodule

// File: rtl/dma_ctxid_resp.sv
module dma_ctxid_resp
    import dma_ctxid_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  acc_verdict_t       verdict,
    input  logic               acc_write,
    input  logic [WORD_W-1:0]  rd_word,
    output logic               rsp_valid,
    output logic               rsp_undef,
    output logic [WORD_W-1:0]  rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_undef <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (verdict != ACC_NONE);
            rsp_undef <= (verdict == ACC_DENY);
            rsp_rdata <= ((verdict == ACC_GRANT) && !acc_write) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/dma_ctxid_bank.sv
module dma_ctxid_bank
    import dma_ctxid_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [2:0]                 acc_op1,
    input  logic [3:0]                 acc_crn,
    input  logic [3:0]                 acc_crm,
    input  logic [2:0]                 acc_op2,
    input  logic [31:0]                acc_wdata,
    input  logic                       acc_priv,
    input  logic                       acc_secure,
    input  logic                       ns_dma_en,
    input  logic [SEL_W-1:0]           chan_sel,
    input  logic [NUM_CH-1:0]          chan_busy,
    output logic                       rsp_valid,
    output logic                       rsp_undef,
    output logic [31:0]                rsp_rdata,
    output logic [NUM_CH*8-1:0]        asid_out
);

    sysreg_addr_t        addr;
    acc_verdict_t        verdict;
    logic                sel_ok;
    logic [NUM_CH-1:0]   wr_vec;
    logic [WORD_W-1:0]   rd_word;

    assign addr = '{op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

    dma_ctxid_gate #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_gate (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .addr      (addr),
        .priv      (acc_priv),
        .secure    (acc_secure),
        .ns_en     (ns_dma_en),
        .chan_sel  (chan_sel),
        .chan_busy (chan_busy),
        .verdict   (verdict),
        .sel_ok    (sel_ok),
        .wr_vec    (wr_vec)
    );

    dma_ctxid_store #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_vec    (wr_vec),
        .wr_data   (acc_wdata),
        .rd_idx    (chan_sel),
        .rd_ok     (sel_ok),
        .rd_word   (rd_word),
        .asid_flat (asid_out)
    );

    dma_ctxid_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .acc_write (acc_write),
        .rd_word   (rd_word),
        .rsp_valid (rsp_valid),
        .rsp_undef (rsp_undef),
        .rsp_rdata (rsp_rdata)
    );

    // Port-level decode used only by the properties below.
    logic port_hit;
    assign port_hit = acc_valid && (acc_op1 == 3'd0) && (acc_crn == 4'd11) &&
                      (acc_crm == 4'd15) && (acc_op2 == 3'd0);

    p_resp_latency_r9: assert property (@(posedge clk) disable iff (rst)
        port_hit |=> rsp_valid);

    p_no_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !port_hit |=> !rsp_valid);

    p_user_undef_r3: assert property (@(posedge clk) disable iff (rst)
        (port_hit && !acc_priv) |=> (rsp_undef && rsp_rdata == '0));

    p_secure_ok_r4: assert property (@(posedge clk) disable iff (rst)
        (port_hit && acc_priv && acc_secure) |=> !rsp_undef);

    p_ns_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (port_hit && acc_priv && !acc_secure) |=> (rsp_undef == !$past(ns_dma_en)));

    p_oor_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (port_hit && !acc_write && ({1'b0, chan_sel} >= (SEL_W + 1)'(NUM_CH)))
            |=> (rsp_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_busy_chk
        p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
            chan_busy[c] |=> $stable(asid_out[c*8 +: 8]));
    end

endmodule

// File: tb/dma_ctxid_bank_test.sv
module dma_ctxid_bank_test;

    localparam int NCH = 2;
    localparam int SW  = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              acc_valid, acc_write, acc_priv, acc_secure, ns_dma_en;
    logic [2:0]        acc_op1, acc_op2;
    logic [3:0]        acc_crn, acc_crm;
    logic [31:0]       acc_wdata;
    logic [SW-1:0]     chan_sel;
    logic [NCH-1:0]    chan_busy;
    logic              rsp_valid, rsp_undef;
    logic [31:0]       rsp_rdata;
    logic [NCH*8-1:0]  asid_out;

    always #5 clk = ~clk;

    dma_ctxid_bank #(.NUM_CH(NCH), .SEL_W(SW)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
        .acc_wdata(acc_wdata), .acc_priv(acc_priv), .acc_secure(acc_secure),
        .ns_dma_en(ns_dma_en), .chan_sel(chan_sel), .chan_busy(chan_busy),
        .rsp_valid(rsp_valid), .rsp_undef(rsp_undef), .rsp_rdata(rsp_rdata),
        .asid_out(asid_out)
    );

    logic [31:0] model [NCH];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic f_hit(input logic [2:0] o1, input logic [3:0] n,
                                   input logic [3:0] m, input logic [2:0] o2);
        return (o1 == 3'd0) && (n == 4'd11) && (m == 4'd15) && (o2 == 3'd0);
    endfunction

    function automatic logic f_allow(input logic priv, input logic sec, input logic en);
        return priv && (sec || en);
    endfunction

    function automatic string f_tag(input logic hit, input logic wr, input logic sec,
                                    input logic priv, input logic oor, input logic bsy);
        if (!hit)            return "R2";
        else if (!priv)      return "R3";
        else if (!sec)       return "R5";
        else if (oor)        return "R8";
        else if (wr && bsy)  return "R6";
        else                 return "R4";
    endfunction

    task automatic check_asid();
        for (int c = 0; c < NCH; c++)
            check("R10", $sformatf("asid ch%0d", c), 32'(asid_out[c*8 +: 8]),
                  32'(model[c][7:0]));
    endtask

    task automatic access(input logic wr, input logic sec, input logic priv,
                          input logic en, input logic [SW-1:0] sel,
                          input logic [NCH-1:0] busy, input logic [31:0] data,
                          input logic [2:0] o1, input logic [3:0] n,
                          input logic [3:0] m, input logic [2:0] o2);
        logic hit, ok, oor, bsy;
        logic [31:0] exp_rd;
        string tag;
        hit = f_hit(o1, n, m, o2);
        ok  = f_allow(priv, sec, en);
        oor = (int'(sel) >= NCH);
        bsy = oor ? 1'b0 : busy[int'(sel)];
        tag = f_tag(hit, wr, sec, priv, oor, bsy);
        exp_rd = (hit && ok && !wr && !oor) ? model[int'(sel)] : 32'd0;
        acc_valid = 1'b1; acc_write = wr; acc_secure = sec; acc_priv = priv;
        ns_dma_en = en; chan_sel = sel; chan_busy = busy; acc_wdata = data;
        acc_op1 = o1; acc_crn = n; acc_crm = m; acc_op2 = o2;
        @(negedge clk);
        // R9: the response is registered at the strobe edge, visible now
        check(tag, "rsp_valid (R9)", 32'(rsp_valid), 32'(hit));
        check(tag, "rsp_undef", 32'(rsp_undef), 32'(hit && !ok));
        check(tag, "rsp_rdata (R9)", rsp_rdata, exp_rd);
        acc_valid = 1'b0;
        chan_busy = '0;
        if (hit && ok && wr && !oor && !bsy)
            model[int'(sel)] = data;
        check_asid();
    endtask

    task automatic read_back(input string tag, input int ch);
        access(1'b0, 1'b1, 1'b1, 1'b0, SW'(ch), '0, 32'd0, 3'd0, 4'd11, 4'd15, 3'd0);
        check(tag, $sformatf("readback ch%0d", ch), rsp_rdata, model[ch]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) model[c] = 32'd0;
        rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_priv = 1'b0;
        acc_secure = 1'b0; ns_dma_en = 1'b0; chan_sel = '0; chan_busy = '0;
        acc_wdata = '0; acc_op1 = '0; acc_crn = '0; acc_crm = '0; acc_op2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1", "rsp_valid idle", 32'(rsp_valid), 32'd0);
        check("R1", "asid_out", 32'(asid_out), 32'd0);
        for (int c = 0; c < NCH; c++) read_back("R1", c);

        // R4: secure write then read
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '0, 32'hA5A5_5A17, 3'd0, 4'd11, 4'd15, 3'd0);
        read_back("R4", 0);
        // R7: a write to channel 1 leaves channel 0 alone
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd1, '0, 32'h1234_56C3, 3'd0, 4'd11, 4'd15, 3'd0);
        read_back("R7", 0);
        read_back("R7", 1);
        // R5: non-secure refused without enable, granted with it
        access(1'b1, 1'b0, 1'b1, 1'b0, 4'd0, '0, 32'hDEAD_BEEF, 3'd0, 4'd11, 4'd15, 3'd0);
        read_back("R5", 0);
        access(1'b1, 1'b0, 1'b1, 1'b1, 4'd0, '0, 32'h0BAD_F00D, 3'd0, 4'd11, 4'd15, 3'd0);
        access(1'b0, 1'b0, 1'b1, 1'b1, 4'd0, '0, 32'd0, 3'd0, 4'd11, 4'd15, 3'd0);
        // R3: user mode read and write refused
        access(1'b1, 1'b1, 1'b0, 1'b1, 4'd1, '0, 32'hFFFF_FFFF, 3'd0, 4'd11, 4'd15, 3'd0);
        access(1'b0, 1'b1, 1'b0, 1'b1, 4'd1, '0, 32'd0, 3'd0, 4'd11, 4'd15, 3'd0);
        read_back("R3", 1);
        // R6: busy channel ignores a write
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd1, 2'b10, 32'h7777_7777, 3'd0, 4'd11, 4'd15, 3'd0);
        read_back("R6", 1);
        // R8: out of range select
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd2, '0, 32'h9999_9999, 3'd0, 4'd11, 4'd15, 3'd0);
        access(1'b0, 1'b1, 1'b1, 1'b0, 4'd15, '0, 32'd0, 3'd0, 4'd11, 4'd15, 3'd0);
        read_back("R8", 0);
        read_back("R8", 1);
        // R2: near-miss decodes
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '0, 32'h5555_5555, 3'd0, 4'd11, 4'd14, 3'd0);
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '0, 32'h5555_5555, 3'd0, 4'd11, 4'd15, 3'd1);
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '0, 32'h5555_5555, 3'd1, 4'd11, 4'd15, 3'd0);
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '0, 32'h5555_5555, 3'd0, 4'd12, 4'd15, 3'd0);
        read_back("R2", 0);

        // Random mix
        for (int i = 0; i < 800; i++) begin
            logic good;
            logic [2:0] o1, o2;
            logic [3:0] n, m;
            good = ($urandom % 100) < 85;
            o1 = good ? 3'd0  : 3'($urandom);
            n  = good ? 4'd11 : 4'($urandom);
            m  = good ? 4'd15 : 4'($urandom);
            o2 = good ? 3'd0  : 3'($urandom);
            access(1'($urandom), 1'($urandom), ($urandom % 100) < 80, 1'($urandom),
                   SW'($urandom % 5),
                   {(($urandom % 4) == 0), (($urandom % 4) == 0)},
                   $urandom, o1, n, m, o2);
        end
        for (int c = 0; c < NCH; c++) read_back("R4", c);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule